// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup battery gets a load test and remembers the outcome. When main power is good and the power-up recovery interval has ended, it runs a test at once. After that it runs one test per interval, which is 24 hours of 1 Hz ticks by default. During a test it raises a load-enable output for a fixed number of seconds. On the tick that ends the window, it takes the result from an external comparator that flags a low battery.

The warning output is a latch. A failing test sets it. Only a later passing test clears it. A drop of main power does not clear it. While power is bad or recovery is still in progress, the block does not schedule tests, and it aborts any test in progress. When power returns, the block runs a fresh test and restarts the interval count from that test.

The analog comparator, the test resistor and the pin driver are outside the block.

Top module: `bts_sched`

## Requirements
- R1: After reset, `load_en` and `batt_warn` are both 0.
- R2: In any cycle where `pwr_good` or `recov_done` is low, `load_en` is 0 from the next cycle, and no test is started or finished.
- R3: On the first clock edge where `pwr_good` and `recov_done` are both high after being disabled, a test starts and `load_en` reads 1 after that edge. This happens whatever the value of `batt_warn`.
- R4: A test holds `load_en` high through exactly `TICKS_PER_TEST` sampled `sec_tick` pulses. It falls at the edge that samples the last of these pulses.
- R5: At the edge that ends a test window, `batt_warn` takes the value of `batt_low` (1 = battery below trip). At any other time, `batt_low` has no effect on `batt_warn`.
- R6: Once `batt_warn` is 1, it stays 1 through later failing tests. It returns to 0 only when a test ends with `batt_low` at 0.
- R7: While monitoring stays enabled, each scheduled test starts exactly `TICKS_PER_INTERVAL` ticks after the previous test started.
- R8: If power fails during a test, `load_en` falls on the next cycle and `batt_warn` is unchanged.
- R9: If power fails while the block is waiting between tests, the schedule is dropped. When power returns, a new test starts at once, as in R3.
- R10: `batt_warn` holds its value while power is bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| pwr_good | input | 1 | Main supply above the power-fail point |
| recov_done | input | 1 | Power-up recovery interval has elapsed |
| batt_low | input | 1 | Comparator result: 1 when the battery is below the trip voltage |
| load_en | output | 1 | Connects the test load while 1 |
| batt_warn | output | 1 | Latched battery warning |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- `load_en` rises one clock after monitoring is enabled.
- When a window-ending tick is sampled, `load_en` falls and `batt_warn` updates at that same edge, so both are visible in the following cycle.
- After a power loss, `load_en` drops one cycle later.

The bench drives inputs on falling edges. A behavioural reference model advances on each rising edge, and the outputs are compared against it a short delay after every rising edge, so every result is sampled in the first cycle it is due. The tick-to-tick spacing between scheduled tests is also measured directly, in tick counts rather than cycles.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } bts_state_e;

endpackage

// File: rtl/bts_sec_counter.sv
// Counts step pulses modulo LIMIT; last is high while the count sits at LIMIT-1.
module bts_sec_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.cnt = '0;
        end else if (step) begin
            if (cur_q.cnt == TOP) begin
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign last = (cur_q.cnt == TOP);
endmodule

// File: rtl/bts_warn_latch.sv
// Holds the battery warning; only a capture strobe may change it.
module bts_warn_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic level,
    output logic warn
);
    typedef struct packed {
        logic warn;
    } warn_s;

    warn_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (capture) begin
            nxt_d.warn = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign warn = cur_q.warn;
endmodule

// File: rtl/bts_sched.sv
module bts_sched
    import bts_pkg::*;
#(
    parameter int TICKS_PER_INTERVAL = 86400,
    parameter int TICKS_PER_TEST     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic pwr_good,
    input  logic recov_done,
    input  logic batt_low,
    output logic load_en,
    output logic batt_warn
);
    localparam int HOLD_TICKS = TICKS_PER_INTERVAL - TICKS_PER_TEST;

    typedef struct packed {
        bts_state_e state;
    } fsm_s;

    fsm_s cur_q, nxt_d;

    logic monitor_ok;
    logic win_last;
    logic hold_last;
    logic win_end;
    logic hold_end;
    logic capture;

    assign monitor_ok = pwr_good & recov_done;
    assign win_end    = (cur_q.state == ST_LOAD) & sec_tick & win_last;
    assign hold_end   = (cur_q.state == ST_HOLD) & sec_tick & hold_last;
    assign capture    = monitor_ok & win_end;

    bts_sec_counter #(.LIMIT(TICKS_PER_TEST)) u_win_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((cur_q.state != ST_LOAD) | ~monitor_ok),
        .step  (sec_tick),
        .last  (win_last)
    );

    bts_sec_counter #(.LIMIT(HOLD_TICKS)) u_hold_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((cur_q.state != ST_HOLD) | ~monitor_ok),
        .step  (sec_tick),
        .last  (hold_last)
    );

    bts_warn_latch u_warn (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .level   (batt_low),
        .warn    (batt_warn)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!monitor_ok) begin
            nxt_d.state = ST_IDLE;
        end else begin
            case (cur_q.state)
                ST_IDLE: nxt_d.state = ST_LOAD;
                ST_LOAD: if (win_end)  nxt_d.state = ST_HOLD;
                ST_HOLD: if (hold_end) nxt_d.state = ST_LOAD;
                default: nxt_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign load_en = (cur_q.state == ST_LOAD);
endmodule

// File: rtl/bts_sched_chk.sv
module bts_sched_chk #(
    parameter int TICKS_PER_TEST = 1
) (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic pwr_good,
    input logic recov_done,
    input logic batt_low,
    input logic load_en,
    input logic batt_warn
);
    logic        en;
    logic [31:0] win_seen;
    logic        last_tick;

    assign en        = pwr_good & recov_done;
    assign last_tick = sec_tick && (win_seen == 32'(TICKS_PER_TEST - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_seen <= '0;
        end else if (!load_en) begin
            win_seen <= '0;
        end else if (sec_tick) begin
            win_seen <= win_seen + 1;
        end
    end

    p_off_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !load_en);

    p_start_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> load_en);

    p_window_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && en && !last_tick) |=> load_en);

    p_window_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && en && last_tick) |=> !load_en);

    p_sample_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && en && last_tick) |=> (batt_warn == $past(batt_low)));

    p_warn_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && en && sec_tick) |=> $stable(batt_warn));
endmodule

bind bts_sched bts_sched_chk #(.TICKS_PER_TEST(TICKS_PER_TEST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .pwr_good   (pwr_good),
    .recov_done (recov_done),
    .batt_low   (batt_low),
    .load_en    (load_en),
    .batt_warn  (batt_warn)
);

// File: tb/tb_bts_sched.sv
`timescale 1ns/1ps
module tb_bts_sched;
    localparam int INTERVAL = 8;
    localparam int WINDOW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic pwr_good = 1'b0;
    logic recov_done = 1'b0;
    logic batt_low = 1'b0;
    logic load_en;
    logic batt_warn;

    int n_checks = 0;
    int n_err = 0;
    int ticks_seen = 0;
    string phase_tag = "R1";

    // reference model
    int m_mode = 0;   // 0 idle, 1 testing, 2 waiting
    int m_since = 0;  // ticks since the current test began
    bit m_warn = 1'b0;

    always #10 clk = ~clk;

    bts_sched #(.TICKS_PER_INTERVAL(INTERVAL), .TICKS_PER_TEST(WINDOW)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pwr_good(pwr_good),
        .recov_done(recov_done), .batt_low(batt_low),
        .load_en(load_en), .batt_warn(batt_warn)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_since = 0; m_warn = 1'b0;
        end else begin
            if (sec_tick) ticks_seen++;
            if (!(pwr_good && recov_done)) begin
                m_mode = 0; m_since = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_since = 0;
            end else if (sec_tick) begin
                m_since++;
                if (m_mode == 1 && m_since == WINDOW) begin
                    m_warn = batt_low; m_mode = 2;
                end else if (m_mode == 2 && m_since == INTERVAL) begin
                    m_mode = 1; m_since = 0;
                end
            end
        end
    end

    always @(posedge clk) begin
        #2;
        check(load_en === (m_mode == 1), {phase_tag, " load_en"}, int'(load_en), int'(m_mode == 1));
        check(batt_warn === m_warn, {phase_tag, " batt_warn"}, int'(batt_warn), int'(m_warn));
    end

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    end

    task automatic wait_clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_load(input logic val, input string tag);
        for (int i = 0; i < 500; i++) begin
            if (load_en === val) return;
            @(negedge clk);
        end
        check(1'b0, {tag, " wait timeout"}, int'(load_en), int'(val));
    endtask

    initial begin
        int t0;
        wait_clocks(3);
        check(load_en === 1'b0, "R1 reset load_en", int'(load_en), 0);
        check(batt_warn === 1'b0, "R1 reset warn", int'(batt_warn), 0);
        rst_n = 1'b1;

        phase_tag = "R2";
        pwr_good = 1'b1;
        wait_clocks(40);
        check(load_en === 1'b0, "R2 recovery pending", int'(load_en), 0);

        phase_tag = "R3";
        recov_done = 1'b1;
        batt_low = 1'b1;
        wait_clocks(1);
        check(load_en === 1'b1, "R3 power-up test", int'(load_en), 1);

        phase_tag = "R4";
        wait_load(1'b0, "R4");
        check(batt_warn === 1'b1, "R5 low sampled", int'(batt_warn), 1);

        phase_tag = "R5";
        wait_clocks(2);
        batt_low = 1'b0;
        wait_clocks(8);
        check(batt_warn === 1'b1, "R5 low ignored outside window", int'(batt_warn), 1);
        batt_low = 1'b1;

        phase_tag = "R7";
        wait_load(1'b1, "R7");
        t0 = ticks_seen;
        wait_load(1'b0, "R6");
        check(batt_warn === 1'b1, "R6 stays after failing test", int'(batt_warn), 1);
        wait_load(1'b1, "R7");
        check(ticks_seen - t0 == INTERVAL, "R7 test spacing", ticks_seen - t0, INTERVAL);

        phase_tag = "R6";
        batt_low = 1'b0;
        wait_load(1'b0, "R6");
        check(batt_warn === 1'b0, "R6 cleared by passing test", int'(batt_warn), 0);

        phase_tag = "R8";
        wait_load(1'b1, "R8");
        wait_clocks(2);
        batt_low = 1'b1;
        pwr_good = 1'b0;
        wait_clocks(1);
        check(load_en === 1'b0, "R8 abort on power loss", int'(load_en), 0);
        wait_clocks(40);
        check(batt_warn === 1'b0, "R8 warn unchanged by abort", int'(batt_warn), 0);

        phase_tag = "R9";
        pwr_good = 1'b1;
        wait_clocks(1);
        check(load_en === 1'b1, "R9 retest after return", int'(load_en), 1);
        wait_load(1'b0, "R9");
        wait_clocks(10);
        pwr_good = 1'b0;
        wait_clocks(5);
        pwr_good = 1'b1;
        wait_clocks(1);
        check(load_en === 1'b1, "R9 fresh test after wait-phase loss", int'(load_en), 1);

        phase_tag = "R10";
        wait_load(1'b0, "R10");
        check(batt_warn === 1'b1, "R10 warn set before outage", int'(batt_warn), 1);
        pwr_good = 1'b0;
        batt_low = 1'b0;
        wait_clocks(100);
        check(batt_warn === 1'b1, "R10 warn held through outage", int'(batt_warn), 1);
        pwr_good = 1'b1;
        wait_clocks(1);
        check(load_en === 1'b1, "R3 retest with warning active", int'(load_en), 1);
        wait_load(1'b0, "R6");
        check(batt_warn === 1'b0, "R6 cleared after power-up test", int'(batt_warn), 0);

        wait_clocks(4);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule